// File: doc/BRIEF.md
# Switch Forwarding Decision Engine

This block makes the forwarding decision for each frame a small Ethernet switch receives. A header parser hands it the destination address, the source address, the ingress port and an error flag with a one-cycle strobe. Two cycles later the block returns a decision strobe. The decision either drops the frame, sends it to one network port, or redirects it to the management CPU port. Multicast and broadcast frames go to the CPU, as do frames with an unknown destination and frames whose destination entry carries a CPU tag or an intervention flag.

Alongside each lookup the block learns source addresses into an on-chip, direct-mapped address table. Static entries survive aging and cannot be evicted. A pulse starts an aging sweep that removes dynamic stations which have gone silent. An errored frame is never learned. Its source address is reported to the CPU instead. A host port reads and writes any table entry by index.

Top module: `fwd_engine`

## Requirements
- R1: When a header strobe `hdr_valid` is sampled, `dec_valid` is high for exactly one cycle, two clock cycles later. The lookup sees the table as it stood before that frame's own learning.
- R2: A destination with bit 40 set (the group bit, the LSB of the first octet) gives code 2 (CPU) with `dec_port` equal to `CPU_PORT`. This covers multicast and broadcast.
- R3: A unicast destination that matches no valid entry gives code 2 with port `CPU_PORT`.
- R4: A known unicast destination whose entry has its CPU tag or its intervention flag set gives code 2 with port `CPU_PORT`.
- R5: A known unicast destination with neither flag set gives one of two results. If the stored port differs from the ingress port, the result is code 1 with the stored port. If it equals the ingress port, the result is code 0 (drop) with the ingress port.
- R6: An error-free frame with a unicast source address learns that address at table index = the low IW bits of CRC-8 over the address. The CRC uses polynomial 0x07 and initial value 0, with bit 47 shifted in first. A new entry is valid, dynamic, untagged, records the ingress port and has its hit bit set. A dynamic entry that already holds the address updates its port and sets its hit bit.
- R7: When a learn collides with a different address, that address overwrites a dynamic entry. A static entry is left unchanged.
- R8: An errored frame gives code 0 with the ingress port. It raises `err_valid` in the decision cycle with `err_sa` equal to its source address, and it changes no table entry.
- R9: A source address with bit 40 set is never stored.
- R10: A pulse on `age_start` sweeps the table one index per cycle over 2^IW cycles. Each valid dynamic entry has its hit bit cleared if it was set, or is invalidated if it was clear. Static entries are untouched.
- R11: A host write stores all entry fields at `host_idx`, with the hit bit cleared. A host read returns the entry with `host_rvalid` one cycle after the request.
- R12: After reset every entry is invalid and `dec_valid` and `err_valid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hdr_valid | input | 1 | Header strobe |
| hdr_da | input | 48 | Destination address |
| hdr_sa | input | 48 | Source address |
| hdr_port | input | PW | Ingress port |
| hdr_err | input | 1 | Frame received with error |
| dec_valid | output | 1 | Decision strobe |
| dec_code | output | 2 | 0 drop, 1 port, 2 CPU |
| dec_port | output | PW | Destination port |
| err_valid | output | 1 | Errored-frame report strobe |
| err_sa | output | 48 | Source address of errored frame |
| age_start | input | 1 | Start aging sweep |
| host_req | input | 1 | Host access request |
| host_wr | input | 1 | 1 write, 0 read |
| host_idx | input | IW | Entry index |
| host_wvalid | input | 1 | Write: entry valid |
| host_wmac | input | 48 | Write: address |
| host_wport | input | PW | Write: port |
| host_wstatic | input | 1 | Write: static |
| host_wcpu | input | 1 | Write: CPU tag |
| host_wintv | input | 1 | Write: intervention flag |
| host_rvalid | output | 1 | Read data strobe |
| rd_valid | output | 1 | Read: entry valid |
| rd_mac | output | 48 | Read: address |
| rd_port | output | PW | Read: port |
| rd_static | output | 1 | Read: static |
| rd_cpu | output | 1 | Read: CPU tag |
| rd_intv | output | 1 | Read: intervention flag |
| rd_hit | output | 1 | Read: hit bit |

## Verification
The bench builds the block with PORTS=4, IW=4 and CPU_PORT=3. That gives a 16-entry table, so a pool of twenty stations collides often and both the dynamic-overwrite and static-protect paths are reached by random traffic. The bench also searches for address pairs with the same index to force collisions on purpose. The short table also keeps an aging sweep down to 16 cycles, so repeated sweeps can bring entries through hit-clear and then invalidation within a short run. A final read of every index compares the whole table against the bench model.

// File: rtl/fwd_engine.sv
module fwd_engine #(
  parameter int PORTS    = 8,
  parameter int IW       = 6,
  parameter int CPU_PORT = PORTS - 1,
  localparam int PW      = (PORTS > 1) ? $clog2(PORTS) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          hdr_valid,
  input  logic [47:0]   hdr_da,
  input  logic [47:0]   hdr_sa,
  input  logic [PW-1:0] hdr_port,
  input  logic          hdr_err,
  output logic          dec_valid,
  output logic [1:0]    dec_code,
  output logic [PW-1:0] dec_port,
  output logic          err_valid,
  output logic [47:0]   err_sa,
  input  logic          age_start,
  input  logic          host_req,
  input  logic          host_wr,
  input  logic [IW-1:0] host_idx,
  input  logic          host_wvalid,
  input  logic [47:0]   host_wmac,
  input  logic [PW-1:0] host_wport,
  input  logic          host_wstatic,
  input  logic          host_wcpu,
  input  logic          host_wintv,
  output logic          host_rvalid,
  output logic          rd_valid,
  output logic [47:0]   rd_mac,
  output logic [PW-1:0] rd_port,
  output logic          rd_static,
  output logic          rd_cpu,
  output logic          rd_intv,
  output logic          rd_hit
);
  localparam int DEPTH = 1 << IW;
  localparam logic [1:0] C_DROP = 2'd0, C_PORT = 2'd1, C_CPU = 2'd2;
  localparam logic [PW-1:0] CPU_P = PW'(CPU_PORT);

  function automatic logic [7:0] crc8(input logic [47:0] m);
    logic [7:0] c;
    logic fb;
    c = 8'h00;
    for (int i = 47; i >= 0; i--) begin
      fb = c[7] ^ m[i];
      c  = {c[6:0], 1'b0} ^ (fb ? 8'h07 : 8'h00);
    end
    return c;
  endfunction

  logic [47:0]   t_mac  [DEPTH];
  logic [PW-1:0] t_port [DEPTH];
  logic          t_v    [DEPTH];
  logic          t_st   [DEPTH];
  logic          t_cpu  [DEPTH];
  logic          t_intv [DEPTH];
  logic          t_hit  [DEPTH];

  logic          s1_v, s1_err;
  logic [47:0]   s1_da, s1_sa;
  logic [PW-1:0] s1_port;

  always_ff @(posedge clk) begin
    if (!rst_n) s1_v <= 1'b0;
    else        s1_v <= hdr_valid;
    if (hdr_valid) begin
      s1_da <= hdr_da; s1_sa <= hdr_sa; s1_port <= hdr_port; s1_err <= hdr_err;
    end
  end

  logic [7:0]    da_crc, sa_crc;
  logic [IW-1:0] da_idx, sa_idx;
  assign da_crc = crc8(s1_da);
  assign sa_crc = crc8(s1_sa);
  assign da_idx = da_crc[IW-1:0];
  assign sa_idx = sa_crc[IW-1:0];

  wire da_known = t_v[da_idx] && (t_mac[da_idx] == s1_da);
  wire sa_match = t_v[sa_idx] && (t_mac[sa_idx] == s1_sa);
  wire learn_en = s1_v && !s1_err && !s1_sa[40];

  logic [1:0]    d_code;
  logic [PW-1:0] d_port;
  always_comb begin
    d_code = C_CPU;
    d_port = CPU_P;
    if (s1_err) begin
      d_code = C_DROP; d_port = s1_port;
    end else if (s1_da[40] || !da_known || t_cpu[da_idx] || t_intv[da_idx]) begin
      d_code = C_CPU; d_port = CPU_P;
    end else if (t_port[da_idx] == s1_port) begin
      d_code = C_DROP; d_port = s1_port;
    end else begin
      d_code = C_PORT; d_port = t_port[da_idx];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dec_valid <= 1'b0; err_valid <= 1'b0;
      dec_code <= C_DROP; dec_port <= '0; err_sa <= '0;
    end else begin
      dec_valid <= s1_v;
      err_valid <= s1_v && s1_err;
      if (s1_v) begin
        dec_code <= d_code; dec_port <= d_port;
      end
      if (s1_v && s1_err) err_sa <= s1_sa;
    end
  end

  logic          age_run;
  logic [IW-1:0] age_idx;
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      age_run <= 1'b0; age_idx <= '0;
    end else if (!age_run) begin
      if (age_start) begin age_run <= 1'b1; age_idx <= '0; end
    end else begin
      if (age_idx == IW'(DEPTH - 1)) age_run <= 1'b0;
      age_idx <= age_idx + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) begin
        t_v[i] <= 1'b0; t_hit[i] <= 1'b0; t_st[i] <= 1'b0;
        t_cpu[i] <= 1'b0; t_intv[i] <= 1'b0; t_mac[i] <= '0; t_port[i] <= '0;
      end
    end else begin
      if (age_run && t_v[age_idx] && !t_st[age_idx]) begin
        if (t_hit[age_idx]) t_hit[age_idx] <= 1'b0;
        else                t_v[age_idx]   <= 1'b0;
      end
      if (learn_en) begin
        if (sa_match) begin
          t_v[sa_idx] <= 1'b1; t_hit[sa_idx] <= 1'b1;
          if (!t_st[sa_idx]) t_port[sa_idx] <= s1_port;
        end else if (!t_v[sa_idx] || !t_st[sa_idx]) begin
          t_v[sa_idx] <= 1'b1; t_mac[sa_idx] <= s1_sa; t_port[sa_idx] <= s1_port;
          t_st[sa_idx] <= 1'b0; t_cpu[sa_idx] <= 1'b0; t_intv[sa_idx] <= 1'b0;
          t_hit[sa_idx] <= 1'b1;
        end
      end
      if (host_req && host_wr) begin
        t_v[host_idx] <= host_wvalid; t_mac[host_idx] <= host_wmac;
        t_port[host_idx] <= host_wport; t_st[host_idx] <= host_wstatic;
        t_cpu[host_idx] <= host_wcpu; t_intv[host_idx] <= host_wintv;
        t_hit[host_idx] <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) host_rvalid <= 1'b0;
    else        host_rvalid <= host_req && !host_wr;
    if (host_req && !host_wr) begin
      rd_valid <= t_v[host_idx]; rd_mac <= t_mac[host_idx]; rd_port <= t_port[host_idx];
      rd_static <= t_st[host_idx]; rd_cpu <= t_cpu[host_idx];
      rd_intv <= t_intv[host_idx]; rd_hit <= t_hit[host_idx];
    end
  end

  AST_DEC_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    dec_valid |-> $past(hdr_valid, 2)); // R1
  AST_GROUP_TO_CPU: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_valid && $past(hdr_da[40], 2) && !$past(hdr_err, 2)) |-> (dec_code == C_CPU)); // R2
  AST_NO_SELF_FWD: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_valid && dec_code == C_PORT) |-> (dec_port != $past(hdr_port, 2))); // R5
  AST_ERR_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    err_valid |-> (dec_valid && dec_code == C_DROP)); // R8
  AST_SWEEP_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    (age_run && age_idx == IW'(DEPTH - 1)) |=> !age_run); // R10
endmodule

// File: tb/sim_fwd_engine.sv
module sim_fwd_engine;
  localparam int PORTS = 4, IW = 4, CPU_PORT = 3;
  localparam int PW = 2, DEPTH = 16;

  logic clk = 0, rst_n = 0;
  always #4 clk = ~clk;

  logic          hdr_valid = 0, hdr_err = 0;
  logic [47:0]   hdr_da = 0, hdr_sa = 0;
  logic [PW-1:0] hdr_port = 0;
  logic          dec_valid, err_valid;
  logic [1:0]    dec_code;
  logic [PW-1:0] dec_port;
  logic [47:0]   err_sa;
  logic          age_start = 0, host_req = 0, host_wr = 0;
  logic [IW-1:0] host_idx = 0;
  logic          host_wvalid = 0, host_wstatic = 0, host_wcpu = 0, host_wintv = 0;
  logic [47:0]   host_wmac = 0;
  logic [PW-1:0] host_wport = 0;
  logic          host_rvalid, rd_valid, rd_static, rd_cpu, rd_intv, rd_hit;
  logic [47:0]   rd_mac;
  logic [PW-1:0] rd_port;

  fwd_engine #(.PORTS(PORTS), .IW(IW), .CPU_PORT(CPU_PORT)) u0 (.*);

  int total = 0, bad = 0;
  bit done = 0;

  logic [47:0]   m_mac  [DEPTH];
  logic [PW-1:0] m_port [DEPTH];
  logic          m_v [DEPTH], m_st [DEPTH], m_cpu [DEPTH], m_intv [DEPTH], m_hit [DEPTH];

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [IW-1:0] hix(logic [47:0] m);
    logic [7:0] c = 0;
    logic fb;
    for (int i = 47; i >= 0; i--) begin
      fb = c[7] ^ m[i];
      c = {c[6:0], 1'b0} ^ (fb ? 8'h07 : 8'h00);
    end
    return c[IW-1:0];
  endfunction

  task automatic frame(logic [47:0] da, logic [47:0] sa, logic [PW-1:0] p, logic e);
    logic [1:0] ec;
    logic [PW-1:0] ep;
    logic [IW-1:0] di, si;
    di = hix(da); si = hix(sa);
    if (e) begin ec = 0; ep = p; end
    else if (da[40] || !(m_v[di] && m_mac[di] == da) || m_cpu[di] || m_intv[di]) begin
      ec = 2; ep = PW'(CPU_PORT);
    end else if (m_port[di] == p) begin ec = 0; ep = p; end
    else begin ec = 1; ep = m_port[di]; end
    @(negedge clk);
    hdr_valid = 1; hdr_da = da; hdr_sa = sa; hdr_port = p; hdr_err = e;
    @(negedge clk);
    hdr_valid = 0;
    chk("R1 early", {63'd0, dec_valid}, 64'd0);
    @(negedge clk);
    chk("R1 strobe", {63'd0, dec_valid}, 64'd1);
    chk("R2-R5 code", {62'd0, dec_code}, {62'd0, ec});
    chk("R2-R5 port", {62'd0, dec_port}, {62'd0, ep});
    chk("R8 errv", {63'd0, err_valid}, {63'd0, e});
    if (e) chk("R8 errsa", {16'd0, err_sa}, {16'd0, sa});
    if (!e && !sa[40]) begin
      if (m_v[si] && m_mac[si] == sa) begin
        m_hit[si] = 1; if (!m_st[si]) m_port[si] = p;
      end else if (!m_v[si] || !m_st[si]) begin
        m_v[si] = 1; m_mac[si] = sa; m_port[si] = p; m_st[si] = 0;
        m_cpu[si] = 0; m_intv[si] = 0; m_hit[si] = 1;
      end
    end
    @(negedge clk);
    chk("R1 one-cycle", {63'd0, dec_valid}, 64'd0);
  endtask

  task automatic hwrite(logic [IW-1:0] i, logic v, logic [47:0] mac, logic [PW-1:0] p,
                        logic st, logic cpu, logic iv);
    @(negedge clk);
    host_req = 1; host_wr = 1; host_idx = i; host_wvalid = v; host_wmac = mac;
    host_wport = p; host_wstatic = st; host_wcpu = cpu; host_wintv = iv;
    @(negedge clk);
    host_req = 0; host_wr = 0;
    m_v[i] = v; m_mac[i] = mac; m_port[i] = p; m_st[i] = st;
    m_cpu[i] = cpu; m_intv[i] = iv; m_hit[i] = 0;
  endtask

  task automatic hcheck(string tag, logic [IW-1:0] i);
    @(negedge clk);
    host_req = 1; host_wr = 0; host_idx = i;
    @(negedge clk);
    host_req = 0;
    chk({tag, " R11 rvalid"}, {63'd0, host_rvalid}, 64'd1);
    chk({tag, " valid"}, {63'd0, rd_valid}, {63'd0, m_v[i]});
    if (m_v[i]) begin
      chk({tag, " mac"}, {16'd0, rd_mac}, {16'd0, m_mac[i]});
      chk({tag, " port/flags"}, {56'd0, rd_port, rd_static, rd_cpu, rd_intv, rd_hit},
          {56'd0, m_port[i], m_st[i], m_cpu[i], m_intv[i], m_hit[i]});
    end
  endtask

  task automatic age();
    @(negedge clk); age_start = 1;
    @(negedge clk); age_start = 0;
    repeat (DEPTH + 2) @(negedge clk);
    for (int i = 0; i < DEPTH; i++)
      if (m_v[i] && !m_st[i]) begin
        if (m_hit[i]) m_hit[i] = 0; else m_v[i] = 0;
      end
  endtask

  function automatic logic [47:0] partner(logic [47:0] base);
    logic [47:0] m = base;
    for (int k = 0; k < 5000; k++) begin
      m = m + 48'h100;
      if (hix(m) == hix(base)) return m;
    end
    return base;
  endfunction

  logic [47:0] pool [20];

  initial begin
    logic [47:0] sS, sA, sB, sC, sD;
    for (int i = 0; i < DEPTH; i++) begin
      m_v[i] = 0; m_hit[i] = 0; m_st[i] = 0; m_cpu[i] = 0; m_intv[i] = 0;
      m_mac[i] = 0; m_port[i] = 0;
    end
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R12 dec_valid", {63'd0, dec_valid}, 64'd0);
    chk("R12 err_valid", {63'd0, err_valid}, 64'd0);
    hcheck("R12 idx0", 0);
    hcheck("R12 idx9", 9);

    sS = 48'h0200_0000_1111;
    hwrite(hix(sS), 1, sS, 1, 1, 0, 0);
    frame(sS, 48'h0200_0000_7001, 0, 0);              // R5 forward
    frame(sS, 48'h0200_0000_7001, 1, 0);              // R5 same port drop
    sC = 48'h0200_0000_2222;
    hwrite(hix(sC), 1, sC, 2, 1, 1, 0);
    frame(sC, 48'h0200_0000_7001, 0, 0);              // R4 cpu tag
    sD = 48'h0200_0000_3333;
    hwrite(hix(sD), 1, sD, 2, 0, 0, 1);
    frame(sD, 48'h0200_0000_7001, 0, 0);              // R4 intervention
    hcheck("R11 hit clear", hix(sD));
    frame(48'h0100_5e00_0001, 48'h0200_0000_7001, 0, 0); // R2 multicast
    frame(48'hffff_ffff_ffff, 48'h0200_0000_7001, 2, 0); // R2 broadcast
    frame(48'h0200_00ab_cdef, 48'h0200_0000_7001, 0, 0); // R3 unknown

    sA = 48'h0200_0000_4444;
    frame(48'hffff_ffff_ffff, sA, 2, 0);
    hcheck("R6 learn", hix(sA));
    frame(sA, 48'h0200_0000_7001, 0, 0);              // R6 learned port
    sB = partner(sA);
    frame(48'hffff_ffff_ffff, sB, 1, 0);
    hcheck("R7 dyn overwrite", hix(sA));
    sC = partner(sS);
    frame(48'hffff_ffff_ffff, sC, 2, 0);
    hcheck("R7 static kept", hix(sS));
    sD = 48'h0200_0000_5555;
    frame(sB, sD, 0, 1);
    hcheck("R8 no learn", hix(sD));
    frame(48'hffff_ffff_ffff, 48'h0300_0000_6666, 0, 0);
    hcheck("R9 group sa", hix(48'h0300_0000_6666));

    age();
    hcheck("R10 hit cleared", hix(sB));
    hcheck("R10 static", hix(sS));
    age();
    hcheck("R10 invalidated", hix(sB));
    hcheck("R10 static kept", hix(sS));

    for (int i = 0; i < 20; i++) pool[i] = {8'h02, 8'h11, 16'd0, 16'(i * 37 + 5)};
    for (int n = 0; n < 400; n++) begin
      logic [47:0] da, sa;
      int r = $urandom_range(0, 9);
      sa = pool[$urandom_range(0, 19)];
      if (r == 0) da = {8'h01, 40'($urandom)};
      else if (r == 1) da = {8'h02, 8'h77, 32'($urandom)};
      else da = pool[$urandom_range(0, 19)];
      frame(da, sa, PW'($urandom_range(0, 2)), ($urandom_range(0, 7) == 0));
      if (n % 90 == 89) age();
    end
    for (int i = 0; i < DEPTH; i++) hcheck("R6 final table", IW'(i));
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(8 * 150000);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog R1 act=hung exp=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule